// File: doc/BRIEF.md
# Control-Bit Memory Window Swapper

This block sits between a CPU bus and the lower 4 MB of a 24-bit address space. It steers each byte or word access to one of two resources: a read-only program image or a 64 KB battery-backed work RAM. One bit of an internal control register picks which half of that space is backed by the RAM. When the bit is clear, the half at or above 0x200000 is the RAM window. When the bit is set, the half below 0x200000 is the RAM window. A write that falls outside the RAM window is dropped and flagged. A read outside the RAM window selects the program image.

Two short aliases near the bottom of the address space load a kill register and the control register. Both registers are held in the block and driven out so that neighbouring logic can use them. When a control write flips the mode bit, the block gives a one-cycle pulse so that any downstream code cache can drop stale lines. Addresses from the register-bank base (0x3BC000) upward are left to an external register bank and produce no activity here.

RAM writes are byte-lane swizzled. The RAM is seen as 32K 16-bit words. Lane 0 of a word is the even byte location and lane 1 is the odd byte location.

Top module: `mem_window_swapper`

## Requirements
- R1: After reset, ctrl_q and kill_q are 0x00, map_changed is low, and the mapping is the mode-clear mapping.
- R2: With ctrl_q bit 2 clear, a write to an address from 0x200000 up to but not including 0x3BC000 asserts ram_we. A write below 0x200000 that is not an alias asserts unhandled_wr, with ram_we low. The window 0x200000–0x20FFFF is part of the upper half.
- R3: With ctrl_q bit 2 set, a non-alias write below 0x200000 asserts ram_we. A write from 0x200000 up to but not including 0x3BC000 asserts unhandled_wr, with ram_we low.
- R4: ram_addr equals CPU address bits 15:1, so the RAM is addressed by the low 16 address bits.
- R5: A byte write stores at the low 16 address bits with bit 0 inverted. An odd CPU address gives ram_be=01 and an even CPU address gives ram_be=10. The data byte is acc_wdata[7:0], and it appears on the enabled lane of ram_wdata (lane 0 = bits 7:0, lane 1 = bits 15:8).
- R6: A word write gives ram_be=11 with ram_wdata equal to acc_wdata. The low data byte goes to the even location and the high data byte to the odd location. Address bit 0 is ignored.
- R7: A byte write to 0x181 loads kill_q, and a byte write to 0x183 loads ctrl_q, each from acc_wdata[7:0] at the next clock edge. Neither raises ram_we or unhandled_wr.
- R8: A word write to 0x180 or 0x182 acts as a byte write of acc_wdata[7:0] to 0x181 or 0x183 respectively.
- R9: A new mode bit governs decoding from the cycle after the control write. map_changed is high for exactly that one cycle, and only if bit 2 changed.
- R10: A read inside the RAM window asserts ram_re. A read elsewhere below 0x3BC000 asserts rom_sel. The two are never high together.
- R11: An access at or above 0x3BC000 asserts none of ram_we, ram_re, rom_sel or unhandled_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe for this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| acc_addr | input | 24 | CPU byte address |
| acc_wdata | input | 16 | Write data (byte accesses use bits 7:0) |
| ram_addr | output | 15 | RAM word address |
| ram_be | output | 2 | RAM byte enables (bit 0 even location, bit 1 odd) |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 16 | RAM write data, lane-ordered |
| ram_re | output | 1 | RAM read select |
| rom_sel | output | 1 | Program image read select |
| unhandled_wr | output | 1 | Write dropped outside the RAM window |
| kill_q | output | 8 | Kill register |
| ctrl_q | output | 8 | Control register |
| map_changed | output | 1 | One-cycle pulse after the mode bit flips |

## Verification
A wrong mode bit shows up on the very next access. Writes that should reach the RAM then come out as unhandled_wr, and reads move between ram_re and rom_sel, so an alternating-half write pattern exposes the error within a cycle. A lane or address swizzle error shows at once on ram_be and ram_wdata during a byte write. A missed or extra map_changed pulse shows one cycle after a control write.

// File: rtl/mem_window_swapper.sv
module mem_window_swapper #(
  parameter int          ADDR_W     = 24,
  parameter int          RAM_AW     = 16,
  parameter int          MODE_BIT   = 2,
  parameter logic [23:0] SPLIT      = 24'h200000,
  parameter logic [23:0] REG_BASE   = 24'h3BC000,
  parameter logic [23:0] KILL_ALIAS = 24'h000181,
  parameter logic [23:0] CTRL_ALIAS = 24'h000183
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_wr,
  input  logic              acc_word,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [15:0]       acc_wdata,
  output logic [RAM_AW-2:0] ram_addr,
  output logic [1:0]        ram_be,
  output logic              ram_we,
  output logic [15:0]       ram_wdata,
  output logic              ram_re,
  output logic              rom_sel,
  output logic              unhandled_wr,
  output logic [7:0]        kill_q,
  output logic [7:0]        ctrl_q,
  output logic              map_changed
);

  logic wr, rd, hi_half, in_space, ram_win, kill_hit, ctrl_hit, alias_hit;

  assign wr       = acc_valid && acc_wr;
  assign rd       = acc_valid && !acc_wr;
  assign hi_half  = acc_addr >= SPLIT[ADDR_W-1:0];
  assign in_space = acc_addr <  REG_BASE[ADDR_W-1:0];
  assign ram_win  = ctrl_q[MODE_BIT] ? !hi_half : hi_half;

  assign kill_hit = wr && (acc_word ? acc_addr[ADDR_W-1:1] == KILL_ALIAS[ADDR_W-1:1]
                                    : acc_addr == KILL_ALIAS[ADDR_W-1:0]);
  assign ctrl_hit = wr && (acc_word ? acc_addr[ADDR_W-1:1] == CTRL_ALIAS[ADDR_W-1:1]
                                    : acc_addr == CTRL_ALIAS[ADDR_W-1:0]);
  assign alias_hit = kill_hit || ctrl_hit;

  assign ram_we       = wr && in_space && ram_win && !alias_hit;
  assign unhandled_wr = wr && in_space && !ram_win && !alias_hit;
  assign ram_re       = rd && in_space && ram_win;
  assign rom_sel      = rd && in_space && !ram_win;

  assign ram_addr  = acc_addr[RAM_AW-1:1];
  assign ram_be    = acc_word ? 2'b11 : (acc_addr[0] ? 2'b01 : 2'b10);
  assign ram_wdata = acc_word ? acc_wdata : {2{acc_wdata[7:0]}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kill_q      <= '0;
      ctrl_q      <= '0;
      map_changed <= 1'b0;
    end else begin
      if (kill_hit) kill_q <= acc_wdata[7:0];
      if (ctrl_hit) ctrl_q <= acc_wdata[7:0];
      map_changed <= ctrl_hit && (acc_wdata[MODE_BIT] != ctrl_q[MODE_BIT]);
    end
  end

  // R2 R3: a write reaches at most one of RAM or the drop flag
  p_we_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && unhandled_wr));
  // R10
  p_rd_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_re && rom_sel));
  // R6
  p_word_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && acc_word) |-> ram_be == 2'b11);
  // R5
  p_byte_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !acc_word) |-> $countones(ram_be) == 1);
  // R9
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    map_changed |-> ctrl_q[MODE_BIT] != $past(ctrl_q[MODE_BIT]));
  // R7
  p_ctrl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_wr) |=> $stable(ctrl_q) && $stable(kill_q));
  // R11
  p_bank_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr >= REG_BASE[ADDR_W-1:0]) |-> !(ram_we || ram_re || rom_sel || unhandled_wr));

endmodule

// File: tb/test_mem_window_swapper.sv
module test_mem_window_swapper;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        acc_valid = 0, acc_wr = 0, acc_word = 0;
  logic [23:0] acc_addr = 0;
  logic [15:0] acc_wdata = 0;
  logic [14:0] ram_addr;
  logic [1:0]  ram_be;
  logic        ram_we, ram_re, rom_sel, unhandled_wr, map_changed;
  logic [15:0] ram_wdata;
  logic [7:0]  kill_q, ctrl_q;

  int checks = 0, fails = 0;
  logic [7:0] m_kill = 0, m_ctrl = 0;
  logic       m_pulse = 0;
  bit         done = 0;

  mem_window_swapper i_mem_window_swapper (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_sel(input logic v, input logic w, input logic wd,
                                         input logic [23:0] a, input logic [7:0] c);
    logic al, sp, win;
    al  = v && w && (wd ? (a[23:1] == 23'h0000C0 || a[23:1] == 23'h0000C1)
                        : (a == 24'h181 || a == 24'h183));
    sp  = a < 24'h3BC000;
    win = c[2] ? (a < 24'h200000) : (a >= 24'h200000);
    // {ram_we, unhandled_wr, ram_re, rom_sel, alias}
    exp_sel = {v && w && sp && win && !al, v && w && sp && !win && !al,
               v && !w && sp && win, v && !w && sp && !win, al};
  endfunction

  task automatic access(input logic w, input logic wd, input logic [23:0] a,
                        input logic [15:0] d, input string req);
    logic [4:0] e;
    logic [1:0] be;
    @(negedge clk);
    acc_valid = 1; acc_wr = w; acc_word = wd; acc_addr = a; acc_wdata = d;
    #1;
    e = exp_sel(1'b1, w, wd, a, m_ctrl);
    chk({req, " sel R2/R3/R10/R11"}, {ram_we, unhandled_wr, ram_re, rom_sel}, e[4:1]);
    chk({req, " addr R4"}, ram_addr, a[15:1]);
    if (e[4]) begin
      be = wd ? 2'b11 : (a[0] ? 2'b01 : 2'b10);
      chk(wd ? "R6 be" : "R5 be", ram_be, be);
      if (wd) chk("R6 data", ram_wdata, d);
      else if (a[0]) chk("R5 lane0", ram_wdata[7:0], d[7:0]);
      else chk("R5 lane1", ram_wdata[15:8], d[7:0]);
    end
    @(posedge clk);
    if (e[0]) begin
      if (wd ? a[1] : a[1]) begin
        m_pulse = (d[2] != m_ctrl[2]);
        m_ctrl = d[7:0];
      end else begin
        m_kill = d[7:0]; m_pulse = 0;
      end
    end else m_pulse = 0;
    #1;
    chk("R7/R8 kill", kill_q, m_kill);
    chk("R7/R8 ctrl", ctrl_q, m_ctrl);
    chk("R9 pulse", map_changed, m_pulse);
    @(negedge clk);
    acc_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 kill", kill_q, 0);
    chk("R1 ctrl", ctrl_q, 0);
    chk("R1 pulse", map_changed, 0);
    @(negedge clk); rst_n = 1;

    // R2: mode clear
    access(1, 0, 24'h200001, 16'h00A5, "R2 hi byte odd");
    access(1, 0, 24'h20FFFE, 16'h003C, "R2 hi byte even");
    access(1, 1, 24'h3BBFFE, 16'hBEEF, "R2 top word");
    access(1, 0, 24'h000400, 16'h0011, "R2 low dropped");
    access(0, 0, 24'h000100, 16'h0000, "R10 rom read");
    access(0, 1, 24'h210000, 16'h0000, "R10 ram read");
    access(1, 0, 24'h3BC001, 16'h0022, "R11 bank");
    access(0, 1, 24'hFFFFFE, 16'h0000, "R11 high");
    // R7/R8 aliases
    access(1, 0, 24'h000181, 16'h0099, "R7 kill");
    access(1, 1, 24'h000180, 16'h7712, "R8 kill word");
    access(1, 0, 24'h000180, 16'h0055, "R7 even not alias");
    // R9: set mode, then confirm swap
    access(1, 0, 24'h000183, 16'h0004, "R9 set mode");
    access(1, 0, 24'h000183, 16'h0005, "R9 no flip");
    access(1, 1, 24'h000400, 16'h1234, "R3 low word");
    access(1, 0, 24'h200000, 16'h0001, "R3 hi dropped");
    access(1, 1, 24'h000182, 16'hFF00, "R8 ctrl word clear");
    access(1, 0, 24'h200000, 16'h0001, "R9 back to clear");

    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      logic [23:0] a;
      r = $urandom;
      case (r[2:0])
        3'd0: a = 24'h000181 + {22'd0, r[3], 1'b0};
        3'd1: a = {8'h20, r[31:16]};
        3'd2: a = 24'h3BC000 + {8'd0, r[31:16]};
        default: a = r[31:10] % 24'h400000;
      endcase
      if (r[2:0] == 3'd0 && r[4]) a = {a[23:1], 1'b0};
      access(r[5] | (r[2:0] == 3'd0), r[4], a, $urandom, "rand");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule